// File: doc/BRIEF.md
# Bisection Phase-Root Finder

This block estimates the phase of one fringe profile. It takes three numbers for that profile: the sine correlation, the cosine correlation and the amplitude. It then looks for the table node at which the least-squares optimality function changes sign. The range [−π, π) is cut into 2^IDX_W nodes, and node k stands for the angle −π + 2πk/2^IDX_W. Three tables, loaded through a write port before use, hold the following values for every node:

- the sine of the node angle;
- the cosine of the node angle;
- an amplitude-correction term derived from the double angle.

The search starts on a bracket made of node 0 and the node half a turn away. For each node it visits, it reads the tables and forms the value of the function. It then halves the stride once per step, moving the left end whenever the pair does not bracket a negative-to-non-negative crossing. When the stride runs out, a single refinement step fixes the last neighbour pair. The block then returns whichever of the two nodes lies closer to the root. The caller converts the index to radians.

The block serves one profile at a time. A caller pulses `start` with the operands held on the inputs, waits for `res_valid` and reads `res_idx`.

Top module: `phase_root_search`

## Requirements
- R1: After reset, `busy` and `res_valid` are 0 and `res_idx` is 0.
- R2: A cycle with `tab_we` high writes `tab_wdata` into the table chosen by `tab_sel` at node `tab_addr`. The encodings are 0 = sine table, 1 = cosine table and 2 = correction table. Entries are two's complement, with unity equal to 2^TAB_FRAC (2^14 by default), and a write changes every search started after it.
- R3: The value at node b is 2·(Is·cos[b] + Ic·sin[b]) − amp·corr[b]. The starting left value is −2·Is·2^TAB_FRAC − amp·corr[0], whatever the sine and cosine tables hold at node 0.
- R4: The search starts with left = 0 and step = right = 2^(IDX_W−1). Each of IDX_W iterations evaluates the right node. When the pair is not bracketed (left value < 0 and right value ≥ 0), left and its value take the right node and its value. The step then halves, and right becomes left + step.
- R5: After the last iteration, if the pair is still not bracketed, right becomes left + 1 and that node is evaluated. Otherwise right becomes left + 1 and the stored right value is kept.
- R6: The result is the left node when |left value| < right value, and the right node otherwise.
- R7: Node indices wrap modulo 2^IDX_W, so a refinement from node 2^IDX_W − 1 evaluates node 0.
- R8: `res_valid` rises 23 clock edges after the edge that accepts `start` when no refinement evaluation occurs, and 25 edges after it when one occurs. Both are within the 40-cycle profile budget.
- R9: `busy` is high from the edge that accepts `start` until the edge that raises `res_valid`. While `busy` is high, `start` and the operand inputs are ignored.
- R10: `res_valid` is high for exactly one cycle per search, and `res_idx` holds its value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tab_we | input | 1 | Table write enable |
| tab_sel | input | 2 | Table select: 0 sine, 1 cosine, 2 correction |
| tab_addr | input | IDX_W | Node written |
| tab_wdata | input | TAB_W | Signed table entry |
| start | input | 1 | Begin a search; taken only when idle |
| corr_sin | input | DATA_W | Signed sine correlation Is |
| corr_cos | input | DATA_W | Signed cosine correlation Ic |
| amp | input | DATA_W | Signed profile amplitude |
| busy | output | 1 | Search in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_idx | output | IDX_W | Chosen node index |

## Verification
Random correlation and amplitude triples run against tables that hold real trigonometric data. These runs exercise many bracket paths, where the left end moves on some steps and stays on others, and they show whether both the refinement branch and the closer-node choice match a bench model of the search. All-zero operands, and a correction table that makes every node value negative, force the left end to climb to the last node. These cases separate a correct wrap to node 0 from a search that overruns the index. Overwriting the sine and cosine entries at node 0 shows whether the starting value ignores those tables, as it should. Starts issued mid-search show whether a busy search is disturbed.

// File: rtl/phs_pkg.sv
package phs_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_INIT_W,
        S_INIT_D,
        S_LOOP_W,
        S_LOOP_D,
        S_FIX_W,
        S_FIX_D,
        S_PICK
    } srch_state_e;

    localparam int N_TAB      = 3;
    localparam int TAB_SINE   = 0;
    localparam int TAB_COSINE = 1;
    localparam int TAB_CORR   = 2;

endpackage

// File: rtl/phs_node_tables.sv
module phs_node_tables #(
    parameter int IDX_W = 10,
    parameter int TAB_W = 16
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [1:0]              wr_sel,
    input  logic [IDX_W-1:0]        wr_addr,
    input  logic signed [TAB_W-1:0] wr_data,
    input  logic                    rd_en,
    input  logic [IDX_W-1:0]        rd_addr,
    output logic signed [TAB_W-1:0] sin_o,
    output logic signed [TAB_W-1:0] cos_o,
    output logic signed [TAB_W-1:0] corr_o
);
    import phs_pkg::*;

    localparam int DEPTH = 1 << IDX_W;

    logic [N_TAB*TAB_W-1:0] rd_flat;

    // One synchronous single-read, single-write RAM per table
    for (genvar g = 0; g < N_TAB; g++) begin : g_tab
        logic signed [TAB_W-1:0] mem [DEPTH];
        logic signed [TAB_W-1:0] dout_q;

        always_ff @(posedge clk) begin
            if (wr_en && (wr_sel == 2'(g))) begin
                mem[wr_addr] <= wr_data;
            end
            if (rd_en) begin
                dout_q <= mem[rd_addr];
            end
        end

        assign rd_flat[g*TAB_W +: TAB_W] = dout_q;
    end

    assign sin_o  = rd_flat[TAB_SINE*TAB_W   +: TAB_W];
    assign cos_o  = rd_flat[TAB_COSINE*TAB_W +: TAB_W];
    assign corr_o = rd_flat[TAB_CORR*TAB_W   +: TAB_W];

endmodule

// File: rtl/phs_eval.sv
module phs_eval #(
    parameter int DATA_W   = 16,
    parameter int TAB_W    = 16,
    parameter int TAB_FRAC = 14,
    parameter int VAL_W    = DATA_W + TAB_W + 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     init_mode,
    input  logic signed [DATA_W-1:0] op_is,
    input  logic signed [DATA_W-1:0] op_ic,
    input  logic signed [DATA_W-1:0] op_amp,
    input  logic signed [TAB_W-1:0]  t_sin,
    input  logic signed [TAB_W-1:0]  t_cos,
    input  logic signed [TAB_W-1:0]  t_corr,
    output logic signed [VAL_W-1:0]  val_o
);
    logic signed [VAL_W-1:0] is_x, ic_x, amp_x;
    logic signed [VAL_W-1:0] sn_x, cs_x, cr_x;
    logic signed [VAL_W-1:0] cos_term, sin_term, corr_term;
    logic signed [VAL_W-1:0] val_d, val_q;

    always_comb begin
        is_x  = VAL_W'(op_is);
        ic_x  = VAL_W'(op_ic);
        amp_x = VAL_W'(op_amp);
        sn_x  = VAL_W'(t_sin);
        cs_x  = VAL_W'(t_cos);
        cr_x  = VAL_W'(t_corr);
        if (init_mode) begin
            // Starting node: cosine of -pi is minus unity, sine is zero
            cos_term = -(is_x <<< TAB_FRAC);
            sin_term = '0;
        end else begin
            cos_term = is_x * cs_x;
            sin_term = ic_x * sn_x;
        end
        corr_term = amp_x * cr_x;
        val_d     = ((cos_term + sin_term) <<< 1) - corr_term;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign val_o = val_q;

endmodule

// File: rtl/phs_search_ctrl.sv
module phs_search_ctrl #(
    parameter int IDX_W  = 10,
    parameter int DATA_W = 16,
    parameter int VAL_W  = 35
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic signed [DATA_W-1:0] in_is,
    input  logic signed [DATA_W-1:0] in_ic,
    input  logic signed [DATA_W-1:0] in_amp,
    input  logic signed [VAL_W-1:0]  val_i,
    output logic                     rd_en_o,
    output logic [IDX_W-1:0]         rd_addr_o,
    output logic                     init_mode_o,
    output logic signed [DATA_W-1:0] op_is_o,
    output logic signed [DATA_W-1:0] op_ic_o,
    output logic signed [DATA_W-1:0] op_amp_o,
    output logic                     busy_o,
    output logic                     res_valid_o,
    output logic [IDX_W-1:0]         res_idx_o
);
    import phs_pkg::*;

    localparam logic [IDX_W-1:0] HALF = IDX_W'(1) << (IDX_W - 1);
    localparam logic [IDX_W-1:0] ONE  = IDX_W'(1);

    typedef struct packed {
        srch_state_e              st;
        logic                     busy;
        logic [IDX_W-1:0]         lft;
        logic [IDX_W-1:0]         rgt;
        logic [IDX_W-1:0]         step;
        logic signed [VAL_W-1:0]  vl;
        logic signed [VAL_W-1:0]  vr;
        logic signed [DATA_W-1:0] op_is;
        logic signed [DATA_W-1:0] op_ic;
        logic signed [DATA_W-1:0] op_amp;
        logic                     vld;
        logic [IDX_W-1:0]         idx;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    logic                    brk, post_brk;
    logic [IDX_W-1:0]        keep_l, half_s, next_r;
    logic signed [VAL_W-1:0] keep_v;
    logic signed [VAL_W:0]   vl_x, vr_x, vl_mag;
    logic                    close_l;

    always_comb begin
        // Bracket test on the stored left value and the fresh right value
        brk      = cur_q.vl[VAL_W-1] && !val_i[VAL_W-1];
        keep_l   = brk ? cur_q.lft : cur_q.rgt;
        keep_v   = brk ? cur_q.vl : val_i;
        half_s   = cur_q.step >> 1;
        next_r   = keep_l + half_s;
        post_brk = keep_v[VAL_W-1] && !val_i[VAL_W-1];
        vl_x     = (VAL_W+1)'(cur_q.vl);
        vr_x     = (VAL_W+1)'(cur_q.vr);
        vl_mag   = vl_x[VAL_W] ? -vl_x : vl_x;
        close_l  = vl_mag < vr_x;

        nxt_d       = cur_q;
        nxt_d.vld   = 1'b0;
        rd_en_o     = 1'b0;
        rd_addr_o   = cur_q.rgt;
        init_mode_o = (cur_q.st == S_INIT_W);

        unique case (cur_q.st)
            S_IDLE: begin
                if (start) begin
                    nxt_d.busy   = 1'b1;
                    nxt_d.op_is  = in_is;
                    nxt_d.op_ic  = in_ic;
                    nxt_d.op_amp = in_amp;
                    nxt_d.lft    = '0;
                    nxt_d.step   = HALF;
                    nxt_d.rgt    = HALF;
                    rd_en_o      = 1'b1;
                    rd_addr_o    = '0;
                    nxt_d.st     = S_INIT_W;
                end
            end
            S_INIT_W: nxt_d.st = S_INIT_D;
            S_INIT_D: begin
                nxt_d.vl  = val_i;
                rd_en_o   = 1'b1;
                rd_addr_o = cur_q.rgt;
                nxt_d.st  = S_LOOP_W;
            end
            S_LOOP_W: nxt_d.st = S_LOOP_D;
            S_LOOP_D: begin
                nxt_d.vr   = val_i;
                nxt_d.lft  = keep_l;
                nxt_d.vl   = keep_v;
                nxt_d.step = half_s;
                if (half_s != '0) begin
                    nxt_d.rgt = next_r;
                    rd_en_o   = 1'b1;
                    rd_addr_o = next_r;
                    nxt_d.st  = S_LOOP_W;
                end else begin
                    // Stride exhausted: right equals left, so moving left
                    // onto right leaves it unchanged; index wraps naturally
                    nxt_d.rgt = keep_l + ONE;
                    if (!post_brk) begin
                        rd_en_o   = 1'b1;
                        rd_addr_o = keep_l + ONE;
                        nxt_d.st  = S_FIX_W;
                    end else begin
                        nxt_d.st  = S_PICK;
                    end
                end
            end
            S_FIX_W: nxt_d.st = S_FIX_D;
            S_FIX_D: begin
                nxt_d.vr = val_i;
                nxt_d.st = S_PICK;
            end
            S_PICK: begin
                nxt_d.idx  = close_l ? cur_q.lft : cur_q.rgt;
                nxt_d.vld  = 1'b1;
                nxt_d.busy = 1'b0;
                nxt_d.st   = S_IDLE;
            end
            default: nxt_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: S_IDLE, default: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign op_is_o     = cur_q.op_is;
    assign op_ic_o     = cur_q.op_ic;
    assign op_amp_o    = cur_q.op_amp;
    assign busy_o      = cur_q.busy;
    assign res_valid_o = cur_q.vld;
    assign res_idx_o   = cur_q.idx;

endmodule

// File: rtl/phase_root_search.sv
module phase_root_search #(
    parameter int IDX_W    = 10,
    parameter int DATA_W   = 16,
    parameter int TAB_W    = 16,
    parameter int TAB_FRAC = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tab_we,
    input  logic [1:0]               tab_sel,
    input  logic [IDX_W-1:0]         tab_addr,
    input  logic signed [TAB_W-1:0]  tab_wdata,
    input  logic                     start,
    input  logic signed [DATA_W-1:0] corr_sin,
    input  logic signed [DATA_W-1:0] corr_cos,
    input  logic signed [DATA_W-1:0] amp,
    output logic                     busy,
    output logic                     res_valid,
    output logic [IDX_W-1:0]         res_idx
);
    localparam int VAL_W = DATA_W + TAB_W + 3;

    logic                     rd_en;
    logic [IDX_W-1:0]         rd_addr;
    logic                     init_mode;
    logic signed [DATA_W-1:0] op_is, op_ic, op_amp;
    logic signed [TAB_W-1:0]  t_sin, t_cos, t_corr;
    logic signed [VAL_W-1:0]  node_val;

    phs_search_ctrl #(
        .IDX_W (IDX_W),
        .DATA_W(DATA_W),
        .VAL_W (VAL_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .in_is      (corr_sin),
        .in_ic      (corr_cos),
        .in_amp     (amp),
        .val_i      (node_val),
        .rd_en_o    (rd_en),
        .rd_addr_o  (rd_addr),
        .init_mode_o(init_mode),
        .op_is_o    (op_is),
        .op_ic_o    (op_ic),
        .op_amp_o   (op_amp),
        .busy_o     (busy),
        .res_valid_o(res_valid),
        .res_idx_o  (res_idx)
    );

    phs_node_tables #(
        .IDX_W(IDX_W),
        .TAB_W(TAB_W)
    ) u_tables (
        .clk    (clk),
        .wr_en  (tab_we),
        .wr_sel (tab_sel),
        .wr_addr(tab_addr),
        .wr_data(tab_wdata),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .sin_o  (t_sin),
        .cos_o  (t_cos),
        .corr_o (t_corr)
    );

    phs_eval #(
        .DATA_W  (DATA_W),
        .TAB_W   (TAB_W),
        .TAB_FRAC(TAB_FRAC),
        .VAL_W   (VAL_W)
    ) u_eval (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_mode(init_mode),
        .op_is    (op_is),
        .op_ic    (op_ic),
        .op_amp   (op_amp),
        .t_sin    (t_sin),
        .t_cos    (t_cos),
        .t_corr   (t_corr),
        .val_o    (node_val)
    );

endmodule

// File: rtl/phs_checker.sv
module phs_checker #(
    parameter int IDX_W   = 10,
    parameter int MAX_LAT = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             res_valid,
    input logic [IDX_W-1:0] res_idx
);
    logic [7:0] lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (busy) begin
            if (lat_q != 8'hFF) lat_q <= lat_q + 8'd1;
        end else begin
            lat_q <= '0;
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R10
    AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> $stable(res_idx)); // R10
    AST_RESULT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !busy); // R9
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R9
    AST_BUSY_DROP_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> res_valid); // R9
    AST_LATENCY_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (32'(lat_q) < MAX_LAT)); // R8

endmodule

bind phase_root_search phs_checker #(.IDX_W(IDX_W)) i_phs_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .res_valid(res_valid),
    .res_idx  (res_idx)
);

// File: tb/test_phase_root_search.sv
module test_phase_root_search;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 10;
    localparam int NB         = 1 << IDX_W;
    localparam int DATA_W     = 16;
    localparam int TAB_W      = 16;
    localparam real UNITY     = 16384.0;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     tab_we = 1'b0;
    logic [1:0]               tab_sel = '0;
    logic [IDX_W-1:0]         tab_addr = '0;
    logic signed [TAB_W-1:0]  tab_wdata = '0;
    logic                     start = 1'b0;
    logic signed [DATA_W-1:0] corr_sin = '0;
    logic signed [DATA_W-1:0] corr_cos = '0;
    logic signed [DATA_W-1:0] amp = '0;
    logic                     busy;
    logic                     res_valid;
    logic [IDX_W-1:0]         res_idx;

    int checks = 0;
    int failures = 0;
    int sin_t [NB];
    int cos_t [NB];
    int cor_t [NB];

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_root_search #(.IDX_W(IDX_W), .DATA_W(DATA_W), .TAB_W(TAB_W)) i_phase_root_search (
        .clk(clk), .rst_n(rst_n), .tab_we(tab_we), .tab_sel(tab_sel),
        .tab_addr(tab_addr), .tab_wdata(tab_wdata), .start(start),
        .corr_sin(corr_sin), .corr_cos(corr_cos), .amp(amp),
        .busy(busy), .res_valid(res_valid), .res_idx(res_idx)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint node_val(longint is, longint ic, longint am, int b);
        return 2 * (is * cos_t[b] + ic * sin_t[b]) - am * cor_t[b];
    endfunction

    // Bench model of the search, written from the requirements
    function automatic void ref_search(input longint is, input longint ic, input longint am,
                                       output int idx, output bit fix);
        longint vl, vr, mag;
        int l, r, st;
        vl = -2 * is * 16384 - am * cor_t[0];
        vr = 0;
        l = 0;
        st = NB / 2;
        r = st;
        while (st >= 1) begin
            vr = node_val(is, ic, am, r);
            if (!(vl < 0 && vr >= 0)) begin
                l = r;
                vl = vr;
            end
            st = st / 2;
            r = (l + st) % NB;
        end
        fix = 1'b0;
        if (!(vl < 0 && vr >= 0)) begin
            l = r;
            vl = vr;
            r = (l + 1) % NB;
            vr = node_val(is, ic, am, r);
            fix = 1'b1;
        end else begin
            r = (l + 1) % NB;
        end
        mag = (vl < 0) ? -vl : vl;
        idx = (mag < vr) ? l : r;
    endfunction

    task automatic wr_tab(input int sel, input int addr, input int data);
        @(negedge clk);
        tab_we = 1'b1;
        tab_sel = 2'(sel);
        tab_addr = IDX_W'(addr);
        tab_wdata = TAB_W'(data);
        if (sel == 0) sin_t[addr] = data;
        else if (sel == 1) cos_t[addr] = data;
        else if (sel == 2) cor_t[addr] = data;
    endtask

    task automatic wr_end();
        @(negedge clk);
        tab_we = 1'b0;
    endtask

    task automatic run_one(input int is, input int ic, input int am,
                           input bit poke, input string req);
        int eidx, n, elat;
        bit efix;
        ref_search(is, ic, am, eidx, efix);
        elat = efix ? 25 : 23;
        @(negedge clk);
        corr_sin = DATA_W'(is);
        corr_cos = DATA_W'(ic);
        amp = DATA_W'(am);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R9", "busy after accepted start", longint'(busy), 1);
        n = 0;
        while (!res_valid && n < 100) begin
            if (poke && n == 4) begin
                start = 1'b1;
                corr_sin = DATA_W'(-is + 77);
                corr_cos = DATA_W'(ic / 2 + 5);
                amp = DATA_W'(am / 3 + 1);
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        start = 1'b0;
        check(n == elat, "R8", "result latency", n, elat);
        check(res_idx == IDX_W'(eidx), req, "chosen node", longint'(res_idx), eidx);
        @(posedge clk);
        @(negedge clk);
        check(!res_valid, "R10", "valid pulse width", longint'(res_valid), 0);
        check(res_idx == IDX_W'(eidx), "R10", "index held", longint'(res_idx), eidx);
        check(!busy, "R9", "busy cleared", longint'(busy), 0);
    endtask

    function automatic int rnd_s(int span);
        return int'($urandom_range(0, 2 * span)) - span;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0C1A));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(busy == 1'b0, "R1", "busy at reset", longint'(busy), 0);
        check(res_valid == 1'b0, "R1", "valid at reset", longint'(res_valid), 0);
        check(res_idx == '0, "R1", "index at reset", longint'(res_idx), 0);

        // Real trigonometric tables in Q14
        for (int k = 0; k < NB; k++) begin
            real th;
            th = -3.14159265358979 + 2.0 * 3.14159265358979 * real'(k) / real'(NB);
            wr_tab(0, k, $rtoi($floor(UNITY * $sin(th) + 0.5)));
            wr_tab(1, k, $rtoi($floor(UNITY * $cos(th) + 0.5)));
            wr_tab(2, k, $rtoi($floor(UNITY * (0.3 * $cos(2.0 * th) - 0.2 * $sin(2.0 * th)) + 0.5)));
        end
        wr_end();

        // Directed: zero operands give zero everywhere, forcing climb and wrap
        run_one(0, 0, 0, 1'b0, "R5");
        // Directed: strong cosine only, strong sine only
        run_one(20000, 0, 1000, 1'b0, "R4/R6");
        run_one(0, -20000, 1000, 1'b0, "R4/R6");

        // Random stimulus, some with a start pulse injected mid-search
        for (int i = 0; i < 40; i++) begin
            run_one(rnd_s(20000), rnd_s(20000), int'($urandom_range(0, 20000)),
                    (i % 5) == 0, "R4/R6");
        end

        // Node 0 sine/cosine entries must not affect the starting value
        wr_tab(1, 0, 5000);
        wr_tab(0, 0, -7000);
        wr_end();
        for (int i = 0; i < 6; i++) begin
            run_one(rnd_s(20000), rnd_s(20000), int'($urandom_range(0, 20000)), 1'b0, "R3");
        end

        // Rewritten correction table: every node value negative
        for (int k = 0; k < NB; k++) begin
            wr_tab(2, k, 1000);
        end
        wr_end();
        run_one(0, 0, 100, 1'b0, "R7");
        run_one(rnd_s(20000), rnd_s(20000), int'($urandom_range(0, 20000)), 1'b0, "R2");
        run_one(300, -200, 5000, 1'b1, "R2");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule